// File: doc/BRIEF.md
# Oversampled SPI Slave Front End with Hold

This block is the serial edge of a memory-style SPI target. A fast system clock samples the four pins (select, serial clock, data in, hold) through a synchronizer, finds serial clock edges in its own domain, and assembles incoming bits most significant first into words for a command layer. For each word the command layer hands over a word to send, which the block shifts out on the data out pin, MSB first, with a separate output enable for the tri-state driver. Both idle polarities of the serial clock are accepted: the clock may rest low or high between transfers. In both cases data is captured on rising edges and output changes on falling edges.

A hold pin pauses a transfer partway through a word without losing the bit position. Hold is entered only while selected, on a falling hold pin seen while the serial clock is low. It is left when the hold pin is high while the serial clock is low. While paused, the output driver is off and clock and data activity is ignored. Dropping select during a pause clears the sequence, but the pause stays in force after reselection until it is released.

The receive side is valid/ready with no back-pressure toward the pins: the master owns the clock, so a finished word is always accepted. `rx_valid` stays high until `rx_ready`, and a newer word replaces one that was not taken. The transmit side is offered through `tx_ready`, which is a one-cycle pulse. A word transfers when `tx_valid` is high in that cycle. Otherwise a fill word is sent.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, `sdo_oe`, `rx_valid`, `hold_active` and `tx_ready` are 0 and `bit_cnt` is 0.
- R2: Bits on `sdi` are captured on rising `sck` edges while selected (`cs_n` low), MSB first. After the eighth bit, `rx_data` holds the word and `rx_valid` rises.
- R3: Transfers work the same with `sck` idling low and with `sck` idling high; a falling edge before the first rising edge shifts nothing.
- R4: While selected and not held, `sdo_oe` is 1 and `sdo` presents the current transmit word MSB first. The first bit is valid before the first rising edge, and each following bit changes on a falling edge.
- R5: `tx_ready` pulses once when select falls and once after each eighth captured bit. At that pulse, `tx_data` is loaded if `tx_valid` is 1, else the fill word 0xFF is loaded.
- R6: `rx_valid` stays 1 until a cycle with `rx_ready` high. A word completed while `rx_valid` is still 1 replaces `rx_data`.
- R7: `bit_cnt` gives the number of bits captured in the current word (0 to 7) and returns to 0 when a word completes. `bit_stb` pulses once per captured bit.
- R8: While selected, a high-to-low change of `hold_n` with `sck` low sets `hold_active` and forces `sdo_oe` to 0.
- R9: A high-to-low change of `hold_n` while `sck` is high does not enter hold, even after `sck` then goes low.
- R10: While `hold_active` is 1, `sck` and `sdi` changes are ignored and `bit_cnt` is unchanged. After release, the word continues from the same bit.
- R11: Hold is released only when `hold_n` is high while `sck` is low. Raising `hold_n` with `sck` high keeps the hold until `sck` falls.
- R12: Deasserting select during hold clears `bit_cnt` and the partial word. `hold_active` stays 1 across reselection, so clocks are ignored until release.
- R13: Deasserting select outside hold clears `bit_cnt` and the partial word, and no `rx_valid` is produced for the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data in pin |
| hold_n | input | 1 | Hold pin, active low |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the `sdo` driver |
| hold_active | output | 1 | Transfer is paused |
| bit_stb | output | 1 | One-cycle pulse per captured bit |
| bit_cnt | output | 3 | Bits captured in the current word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Command layer takes the received word |
| rx_data | output | 8 | Received word |
| tx_valid | input | 1 | Command layer offers a transmit word |
| tx_ready | output | 1 | Transmit word load point, one-cycle pulse |
| tx_data | input | 8 | Transmit word |

## Verification
The hardest state to reach from the ports is a hold that outlives a deselect. Select must be dropped partway through a word with the pause in force, and the design reselected while the hold pin is still low. The bench then clocks a whole word that must leave no trace. Only after that does it release the pause and check that a fresh word is received and that the word freshly loaded at reselection is transmitted from its first bit. Directed sequences also pause a word after three bits, with clock and data toggling during the pause. They raise the hold pin while the clock is high, and they drop the hold pin with the clock high. Seeded random transactions cover both idle polarities and several lengths, and are compared against bench-computed words.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  // bit positions of the pins inside the synchronizer vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_HOLD = 3;
  localparam int NUM_PINS = 4;
  // idle level of each pin: select and hold inactive high, clock and data low
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1001;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int                N_PINS  = 4,
  parameter int                STAGES  = 2,
  parameter logic [N_PINS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] lvl_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[p]}};
      else        chain <= {chain[STAGES-2:0], pin_i[p]};
    end
    assign lvl_o[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck_lvl,
  input  logic hold_lvl,
  output logic held
);
  logic hold_prev;
  logic enter, leave;

  assign enter = sel && !sck_lvl && hold_prev && !hold_lvl;
  assign leave = hold_lvl && !sck_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_prev <= 1'b1;
      held      <= 1'b0;
    end else begin
      hold_prev <= hold_lvl;
      if (!held && enter)     held <= 1'b1;
      else if (held && leave) held <= 1'b0;
    end
  end

  assert_hold_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(sel && !sck_lvl && !hold_lvl));
  assert_hold_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(hold_lvl && !sck_lvl));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] FILL_WORD = '1,
  localparam int               CNT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_lvl,
  input  logic              sdi_lvl,
  input  logic              held,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              bit_stb,
  output logic              byte_stb,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] rx_word,
  output logic              sdo_bit
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic              sel_q, sck_q;
  logic              start, rise, fall, last;
  logic [DATA_W-1:0] shreg, tx_reg;
  logic [CNT_W-1:0]  out_idx;

  assign start    = sel && !sel_q;
  assign rise     = sel && !held && sck_lvl && !sck_q;
  assign fall     = sel && !held && !sck_lvl && sck_q;
  assign last     = rise && (bit_cnt == LAST_IDX);
  assign tx_ready = start || last;
  assign sdo_bit  = tx_reg[LAST_IDX - out_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      sck_q    <= 1'b0;
      bit_stb  <= 1'b0;
      byte_stb <= 1'b0;
      bit_cnt  <= '0;
      out_idx  <= '0;
      shreg    <= '0;
      rx_word  <= '0;
      tx_reg   <= FILL_WORD;
    end else begin
      sel_q    <= sel;
      sck_q    <= sck_lvl;
      bit_stb  <= rise;
      byte_stb <= last;
      if (!sel) begin
        bit_cnt <= '0;
        out_idx <= '0;
        shreg   <= '0;
      end else begin
        if (rise) begin
          shreg   <= {shreg[DATA_W-2:0], sdi_lvl};
          bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
        if (fall) out_idx <= bit_cnt;
      end
      if (last)     rx_word <= {shreg[DATA_W-2:0], sdi_lvl};
      if (tx_ready) tx_reg  <= tx_valid ? tx_data : FILL_WORD;
    end
  end

  assert_count_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sel) |=> $stable(bit_cnt));
  assert_word_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (bit_cnt == '0) && ($past(bit_cnt) == LAST_IDX));
  assert_deselect_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] FILL_WORD   = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sck,
  input  logic                       sdi,
  input  logic                       hold_n,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic                       hold_active,
  output logic                       bit_stb,
  output logic [$clog2(DATA_W)-1:0]  bit_cnt,
  output logic                       rx_valid,
  input  logic                       rx_ready,
  output logic [DATA_W-1:0]          rx_data,
  input  logic                       tx_valid,
  output logic                       tx_ready,
  input  logic [DATA_W-1:0]          tx_data
);
  import spi_hold_pkg::*;

  logic [NUM_PINS-1:0] pins, lvl;
  logic                sel, byte_stb;
  logic [DATA_W-1:0]   rx_word;

  always_comb begin
    pins           = '0;
    pins[PIN_CS]   = cs_n;
    pins[PIN_SCK]  = sck;
    pins[PIN_SDI]  = sdi;
    pins[PIN_HOLD] = hold_n;
  end

  spi_pin_sync #(.N_PINS(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl));

  assign sel = !lvl[PIN_CS];

  spi_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_lvl(lvl[PIN_SCK]),
    .hold_lvl(lvl[PIN_HOLD]), .held(hold_active));

  spi_shift_core #(.DATA_W(DATA_W), .FILL_WORD(FILL_WORD)) u_core (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_lvl(lvl[PIN_SCK]),
    .sdi_lvl(lvl[PIN_SDI]), .held(hold_active), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .bit_stb(bit_stb),
    .byte_stb(byte_stb), .bit_cnt(bit_cnt), .rx_word(rx_word), .sdo_bit(sdo));

  assign sdo_oe = sel && !hold_active;

  // single-entry receive slot: newest word wins, no stall toward the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_stb) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assert_rx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
  assert_rx_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(byte_stb));
endmodule

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic rx_ready = 1'b0, tx_valid = 1'b1;
  logic sdo, sdo_oe, hold_active, bit_stb, rx_valid, tx_ready;
  logic [2:0] bit_cnt;
  logic [7:0] rx_data, tx_data;
  int checks = 0, errors = 0, load_idx = 0, ready_cnt = 0, stb_cnt = 0;
  bit mode3 = 1'b0, finished = 1'b0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5) ^ 8'h3C;
  endfunction

  assign tx_data = pat(load_idx);

  always @(posedge clk) begin
    if (tx_ready) begin
      ready_cnt++;
      if (tx_valid) load_idx++;
    end
    if (bit_stb) stb_cnt++;
  end

  spi_hold_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .hold_active(hold_active), .bit_stb(bit_stb),
    .bit_cnt(bit_cnt), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_mode(bit m);
    mode3 = m; sck = m; tick(H);
  endtask

  task automatic sel_on();  cs_n = 1'b0; tick(H); endtask
  task automatic sel_off(); cs_n = 1'b1; tick(H); endtask
  task automatic ack();     rx_ready = 1'b1; tick(1); rx_ready = 1'b0; tick(1); endtask

  task automatic send_bits(input logic [7:0] mo, input int hi, input int lo,
                           inout logic [7:0] mi);
    for (int b = hi; b >= lo; b--) begin
      if (mode3) sck = 1'b0;
      sdi = mo[b];
      tick(H);
      mi[b] = sdo;
      sck = 1'b1;
      tick(H);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic txn(int n, string tag);
    int k;
    logic [7:0] mo, mi;
    k = load_idx;
    sel_on();
    for (int j = 0; j < n; j++) begin
      mo = 8'($urandom);
      mi = '0;
      send_bits(mo, 7, 0, mi);
      tick(4);
      chk({tag, " R2 rx_valid"}, int'(rx_valid), 1);
      chk({tag, " R2 rx_data"}, int'(rx_data), int'(mo));
      chk({tag, " R4 sdo word"}, int'(mi), int'(pat(k + j)));
      ack();
    end
    sel_off();
  endtask

  initial begin
    logic [7:0] mo, mi;
    int k, r0, s0;
    void'($urandom(32'd7351));
    tick(3);
    chk("R1 sdo_oe", int'(sdo_oe), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 hold_active", int'(hold_active), 0);
    chk("R1 tx_ready", int'(tx_ready), 0);
    chk("R1 bit_cnt", int'(bit_cnt), 0);
    rst_n = 1'b1;
    tick(4);

    // idle-low and idle-high clock
    set_mode(1'b0);
    txn(3, "R3 idle-low");
    set_mode(1'b1);
    txn(2, "R3 idle-high");
    set_mode(1'b0);

    // bit counting, strobes and partial word discarded on deselect
    s0 = stb_cnt;
    sel_on();
    chk("R4 sdo_oe selected", int'(sdo_oe), 1);
    mi = '0;
    send_bits(8'hA5, 7, 3, mi);
    tick(2);
    chk("R7 bit_cnt partial", int'(bit_cnt), 5);
    chk("R7 bit_stb count", stb_cnt - s0, 5);
    sel_off();
    chk("R13 bit_cnt cleared", int'(bit_cnt), 0);
    chk("R13 no rx_valid", int'(rx_valid), 0);
    chk("R4 sdo_oe deselected", int'(sdo_oe), 0);
    sel_on();
    mo = 8'h3B;
    send_bits(mo, 7, 0, mi);
    tick(4);
    chk("R13 fresh word", int'(rx_data), int'(mo));
    chk("R7 bit_cnt wrap", int'(bit_cnt), 0);
    ack();
    sel_off();

    // fill word and tx_ready pulses
    tx_valid = 1'b0;
    r0 = ready_cnt;
    sel_on();
    chk("R5 tx_ready at select", ready_cnt - r0, 1);
    mi = '0;
    send_bits(8'h00, 7, 0, mi);
    tick(4);
    chk("R5 fill word", int'(mi), 8'hFF);
    chk("R5 tx_ready after word", ready_cnt - r0, 2);
    ack();
    sel_off();
    tx_valid = 1'b1;

    // newest word wins while unacknowledged
    sel_on();
    mi = '0;
    send_bits(8'h11, 7, 0, mi);
    tick(4);
    send_bits(8'hE7, 7, 0, mi);
    tick(4);
    chk("R6 rx_valid kept", int'(rx_valid), 1);
    chk("R6 overwrite", int'(rx_data), 8'hE7);
    ack();
    chk("R6 cleared by ready", int'(rx_valid), 0);
    sel_off();

    // pause mid-word, noise during pause, resume
    k = load_idx;
    sel_on();
    mo = 8'hC9;
    mi = '0;
    send_bits(mo, 7, 5, mi);
    tick(2);
    hold_n = 1'b0;
    tick(H);
    chk("R8 hold_active", int'(hold_active), 1);
    chk("R8 sdo_oe off", int'(sdo_oe), 0);
    for (int t = 0; t < 3; t++) begin
      sdi = ~sdi; sck = 1'b1; tick(H);
      sdi = ~sdi; sck = 1'b0; tick(H);
    end
    chk("R10 bit_cnt frozen", int'(bit_cnt), 3);
    sck = 1'b1; tick(H);
    hold_n = 1'b1; tick(H);
    chk("R11 still held with sck high", int'(hold_active), 1);
    sck = 1'b0; tick(H);
    chk("R11 released", int'(hold_active), 0);
    chk("R10 bit_cnt after release", int'(bit_cnt), 3);
    send_bits(mo, 4, 0, mi);
    tick(4);
    chk("R10 resumed word", int'(rx_data), int'(mo));
    chk("R10 resumed sdo", int'(mi), int'(pat(k)));
    ack();

    // hold pin falling with clock high does not pause
    sck = 1'b1; tick(H);
    hold_n = 1'b0; tick(H);
    chk("R9 no hold sck high", int'(hold_active), 0);
    sck = 1'b0; tick(H);
    chk("R9 no hold after sck low", int'(hold_active), 0);
    hold_n = 1'b1; tick(H);
    sel_off();

    // deselect during pause, reselect still paused
    sel_on();
    mi = '0;
    send_bits(8'h5A, 7, 4, mi);
    tick(2);
    hold_n = 1'b0; tick(H);
    sel_off();
    chk("R12 bit_cnt cleared", int'(bit_cnt), 0);
    chk("R12 hold kept", int'(hold_active), 1);
    k = load_idx;
    sel_on();
    chk("R12 hold after reselect", int'(hold_active), 1);
    send_bits(8'hFF, 7, 0, mi);
    tick(4);
    chk("R12 clocks ignored", int'(bit_cnt), 0);
    chk("R12 no word", int'(rx_valid), 0);
    hold_n = 1'b1; tick(H);
    chk("R12 released", int'(hold_active), 0);
    mo = 8'h96;
    mi = '0;
    send_bits(mo, 7, 0, mi);
    tick(4);
    chk("R12 word after release", int'(rx_data), int'(mo));
    chk("R12 sdo after release", int'(mi), int'(pat(k)));
    ack();
    sel_off();

    // seeded random transactions
    for (int i = 0; i < 16; i++) begin
      set_mode(1'($urandom));
      txn(1 + int'($urandom % 3), mode3 ? "R3 rnd idle-high" : "R2 rnd idle-low");
    end

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements act=running exp=done");
      report();
    end
  end
endmodule